// File: doc/BRIEF.md
# Conversion Cycle Timer with Clock Divider

This block produces the timing skeleton of an energy measurement engine. It turns the master clock into a divided-clock enable (divide by 1, 2 or 4), groups 1024 divided-clock ticks into one conversion, and groups N conversions into one computation cycle. Instantaneous results downstream are refreshed on every conversion tick. The accumulated energy result is refreshed only on the computation-cycle boundary, and only when N is large enough for the averaged calculations to be meaningful.

A controller writes the 4-bit divider code and the 24-bit cycle count, then pulses start. In single mode the timer runs one computation cycle and then halts. In continuous mode it begins the next cycle in the clock right after the boundary, so no divided-clock tick is lost. The divider code and cycle count are captured at start and again at every continuous restart. Changing them in the middle of a cycle therefore never bends the cycle that is running.

Top module: `conv_cycle_timer`

## Requirements
- R1: While running, `div_tick` is high once every K clocks. `div_code` 4'b0001 gives K=1, 4'b0010 gives K=2 and 4'b0100 gives K=4.
- R2: Any other `div_code` value, 4'b0000 and 4'b0011 included, gives K=1.
- R3: `conv_tick` marks every 1024th divided tick. The first one after an accepted start comes 1024·K clocks after the start-sampling edge.
- R4: `data_rdy` pulses for one clock together with the N-th `conv_tick` of a cycle, so a cycle lasts exactly 1024·K·N clocks and carries N conversion ticks. A cycle count of 0 is handled as 1.
- R5: When `cont_mode` is low at the cycle-end clock, the timer halts. No `div_tick`, `conv_tick` or `data_rdy` follows until a new start.
- R6: When `cont_mode` is high at the cycle-end clock, the next cycle begins at once. Successive `data_rdy` pulses are then spaced exactly 1024·K·N clocks apart.
- R7: `calc_en` is high exactly when the captured cycle count is greater than 10. The count is captured at start and at each continuous restart, and after reset it reads 4000, so `calc_en` is 1.
- R8: `energy_upd` pulses together with `data_rdy` when `calc_en` is high and never pulses otherwise.
- R9: A start pulse that arrives while the timer is running is ignored and does not change the cycle timing.
- R10: During and after reset, before any start, all strobes stay low.
- R11: Changes to `div_code` or `cycle_count` during a cycle take effect only at the next capture point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_code | input | 4 | Clock divider selection code |
| cycle_count | input | 24 | Conversions per computation cycle (N) |
| start_cmd | input | 1 | Start request, accepted only while idle |
| cont_mode | input | 1 | High: restart at cycle end; low: halt at cycle end |
| div_tick | output | 1 | Divided-clock enable |
| conv_tick | output | 1 | End-of-conversion strobe |
| data_rdy | output | 1 | End-of-computation-cycle strobe |
| energy_upd | output | 1 | Energy result update strobe |
| calc_en | output | 1 | RMS and energy calculations allowed |

## Verification
The hardest situation to reach from the ports is a continuous-mode boundary where the divider setting changes while the prescaler phase has to carry over without a lost or doubled tick. The bench runs a divide-by-2 continuous cycle and moves `div_code` to divide by 1 in the middle of the second cycle. It also pulses start in the middle of that cycle. It then checks that the second cycle keeps its old length, that the third cycle is exactly 1024 clocks long, and that clearing `cont_mode` stops the timer after the third cycle. A separate single-mode run changes both settings in the middle of the cycle to show that they are held until the next capture point.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int DIV_CODE_W = 4;
    localparam int DIV_CNT_W  = 2;

    typedef enum logic [1:0] {
        DIV_BY1 = 2'd0,
        DIV_BY2 = 2'd1,
        DIV_BY4 = 2'd2
    } div_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Legal codes are one-hot 1, 2, 4; anything else falls back to divide by 1.
    function automatic div_sel_e decode_div(input logic [DIV_CODE_W-1:0] code);
        div_sel_e sel;
        case (code)
            4'b0010: sel = DIV_BY2;
            4'b0100: sel = DIV_BY4;
            default: sel = DIV_BY1;
        endcase
        return sel;
    endfunction

    // Terminal value of the prescaler counter for a given divider.
    function automatic logic [DIV_CNT_W-1:0] div_last(input div_sel_e sel);
        logic [DIV_CNT_W-1:0] v;
        case (sel)
            DIV_BY2: v = 2'd1;
            DIV_BY4: v = 2'd3;
            default: v = 2'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cct_cfg_capture.sv
module cct_cfg_capture
    import cct_pkg::*;
#(
    parameter int N_W     = 24,
    parameter int N_RESET = 4000,
    parameter int N_MIN   = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [DIV_CODE_W-1:0] div_code,
    input  logic [N_W-1:0]        cycle_count,
    output div_sel_e              div_sel,
    output logic [N_W-1:0]        n_last,
    output logic                  calc_en
);
    localparam logic [N_W-1:0] N_RST_LAST = N_W'(N_RESET - 1);
    localparam logic [N_W-1:0] N_MIN_V    = N_W'(N_MIN);
    localparam logic           CALC_RST   = (N_RESET > N_MIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_sel <= DIV_BY1;
            n_last  <= N_RST_LAST;
            calc_en <= CALC_RST;
        end else if (load) begin
            div_sel <= decode_div(div_code);
            // Store the terminal count so the compare needs no subtractor.
            n_last  <= (cycle_count == '0) ? '0 : cycle_count - N_W'(1);
            calc_en <= (cycle_count > N_MIN_V);
        end
    end
endmodule

// File: rtl/cct_prescaler.sv
module cct_prescaler
    import cct_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  div_sel_e div_sel,
    output logic     div_tick
);
    logic [DIV_CNT_W-1:0] phase_q;
    logic [DIV_CNT_W-1:0] phase_last;

    assign phase_last = div_last(div_sel);
    assign div_tick   = run && (phase_q == phase_last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
        end else if (phase_q == phase_last) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DIV_CNT_W'(1);
        end
    end
endmodule

// File: rtl/cct_tick_counter.sv
module cct_tick_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] last,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign wrap = en && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= (cnt_q == last) ? '0 : cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/conv_cycle_timer.sv
module conv_cycle_timer
    import cct_pkg::*;
#(
    parameter int N_W      = 24,
    parameter int CONV_LEN = 1024,
    parameter int N_RESET  = 4000,
    parameter int N_MIN    = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DIV_CODE_W-1:0] div_code,
    input  logic [N_W-1:0]        cycle_count,
    input  logic                  start_cmd,
    input  logic                  cont_mode,
    output logic                  div_tick,
    output logic                  conv_tick,
    output logic                  data_rdy,
    output logic                  energy_upd,
    output logic                  calc_en
);
    localparam int               CONV_W    = $clog2(CONV_LEN);
    localparam logic [CONV_W-1:0] CONV_LAST = CONV_W'(CONV_LEN - 1);

    run_state_e       state_q;
    logic             run_q;
    logic             start_ok;
    logic             cfg_load;
    div_sel_e         div_sel_q;
    logic [N_W-1:0]   n_last_q;

    assign run_q    = (state_q == ST_RUN);
    assign start_ok = start_cmd && !run_q;
    assign cfg_load = start_ok || (data_rdy && cont_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else if (start_ok) begin
            state_q <= ST_RUN;
        end else if (data_rdy && !cont_mode) begin
            state_q <= ST_IDLE;
        end
    end

    cct_cfg_capture #(
        .N_W     (N_W),
        .N_RESET (N_RESET),
        .N_MIN   (N_MIN)
    ) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .load        (cfg_load),
        .div_code    (div_code),
        .cycle_count (cycle_count),
        .div_sel     (div_sel_q),
        .n_last      (n_last_q),
        .calc_en     (calc_en)
    );

    cct_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q),
        .div_sel  (div_sel_q),
        .div_tick (div_tick)
    );

    cct_tick_counter #(.W(CONV_W)) u_conv_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (start_ok),
        .en   (div_tick),
        .last (CONV_LAST),
        .wrap (conv_tick)
    );

    cct_tick_counter #(.W(N_W)) u_cycle_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (start_ok),
        .en   (conv_tick),
        .last (n_last_q),
        .wrap (data_rdy)
    );

    assign energy_upd = data_rdy && calc_en;

endmodule

// File: rtl/cct_checker.sv
module cct_checker
    import cct_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     div_tick,
    input logic     conv_tick,
    input logic     data_rdy,
    input logic     energy_upd,
    input logic     calc_en,
    input logic     start_cmd,
    input logic     cont_mode,
    input logic     running,
    input div_sel_e div_sel
);
    assert_div_gap_R1: assert property (@(posedge clk) disable iff (rst)
        (div_tick && div_sel != DIV_BY1 && !data_rdy) |=> !div_tick);

    assert_conv_on_div_R3: assert property (@(posedge clk) disable iff (rst)
        conv_tick |-> div_tick);

    assert_ready_on_conv_R4: assert property (@(posedge clk) disable iff (rst)
        data_rdy |-> conv_tick);

    assert_single_halt_R5: assert property (@(posedge clk) disable iff (rst)
        (data_rdy && !cont_mode) |=> (!running && !div_tick));

    assert_cont_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (data_rdy && cont_mode) |=> running);

    assert_calc_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (calc_en != $past(calc_en)) |->
            ($past(start_cmd && !running) || $past(data_rdy && cont_mode)));

    assert_energy_gate_R8: assert property (@(posedge clk) disable iff (rst)
        energy_upd |-> (data_rdy && calc_en));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!div_tick && !conv_tick && !data_rdy));

    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (running && !data_rdy) |=> $stable(div_sel));
endmodule

bind conv_cycle_timer cct_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .div_tick   (div_tick),
    .conv_tick  (conv_tick),
    .data_rdy   (data_rdy),
    .energy_upd (energy_upd),
    .calc_en    (calc_en),
    .start_cmd  (start_cmd),
    .cont_mode  (cont_mode),
    .running    (run_q),
    .div_sel    (div_sel_q)
);

// File: tb/conv_cycle_timer_bench.sv
module conv_cycle_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  div_code = 4'b0001;
    logic [23:0] cycle_count = 24'd1;
    logic        start_cmd = 1'b0;
    logic        cont_mode = 1'b0;
    logic        div_tick, conv_tick, data_rdy, energy_upd, calc_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    conv_cycle_timer u_conv_cycle_timer (
        .clk(clk), .rst(rst), .div_code(div_code), .cycle_count(cycle_count),
        .start_cmd(start_cmd), .cont_mode(cont_mode), .div_tick(div_tick),
        .conv_tick(conv_tick), .data_rdy(data_rdy), .energy_upd(energy_upd),
        .calc_en(calc_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_cmd = 1'b1;
        @(negedge clk) start_cmd = 1'b0;
    endtask

    // Samples from the current negedge (advancing first if adv) until data_rdy.
    task automatic measure(input bit adv, input int limit, output int t_done,
                           output int n_div, output int n_conv, output int first_conv,
                           output int n_energy, output int stray_energy);
        t_done = 0; n_div = 0; n_conv = 0; first_conv = 0; n_energy = 0; stray_energy = 0;
        if (adv) @(negedge clk);
        for (int t = 1; t <= limit; t++) begin
            if (t > 1) @(negedge clk);
            n_div  += int'(div_tick);
            n_conv += int'(conv_tick);
            if (conv_tick && first_conv == 0) first_conv = t;
            if (energy_upd) begin
                n_energy++;
                if (!data_rdy) stray_energy++;
            end
            if (data_rdy) begin
                t_done = t;
                break;
            end
        end
    endtask

    task automatic check_halt(input string req, input int window);
        int seen = 0;
        for (int i = 0; i < window; i++) begin
            @(negedge clk);
            seen += int'(div_tick) + int'(conv_tick) + int'(data_rdy);
        end
        check(seen == 0, req, seen, 0);
    endtask

    task automatic t_reset_state();
        int seen = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            seen += int'(div_tick) + int'(conv_tick) + int'(data_rdy) + int'(energy_upd);
        end
        rst = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            seen += int'(div_tick) + int'(conv_tick) + int'(data_rdy) + int'(energy_upd);
        end
        check(seen == 0, "R10 strobes quiet around reset", seen, 0);
        check(calc_en == 1'b1, "R7 calc_en after reset (count 4000)", int'(calc_en), 1);
    endtask

    task automatic t_single(input logic [3:0] code, input int k, input int n,
                            input string req);
        int td, nd, nc, fc, ne, se, nn, exp_len;
        nn = (n == 0) ? 1 : n;
        exp_len = 1024 * k * nn;
        div_code = code; cycle_count = 24'(n); cont_mode = 1'b0;
        pulse_start();
        measure(1'b0, exp_len + 100, td, nd, nc, fc, ne, se);
        check(td == exp_len, {req, " R4 cycle length"}, td, exp_len);
        check(fc == 1024 * k, {req, " R3 first conv tick"}, fc, 1024 * k);
        check(nc == nn, {req, " R4 conv ticks per cycle"}, nc, nn);
        check(nd == 1024 * nn, {req, " R1 divided ticks per cycle"}, nd, 1024 * nn);
        check(calc_en == (n > 10), {req, " R7 calc_en"}, int'(calc_en), int'(n > 10));
        check(ne == int'(n > 10) && se == 0, {req, " R8 energy strobe"}, ne, int'(n > 10));
        check_halt({req, " R5 halt after single cycle"}, 1500);
    endtask

    task automatic t_continuous();
        int td, nd, nc, fc, ne, se;
        div_code = 4'b0010; cycle_count = 24'd1; cont_mode = 1'b1;
        pulse_start();
        measure(1'b0, 3000, td, nd, nc, fc, ne, se);
        check(td == 2048, "R6 first continuous cycle", td, 2048);
        fork
            begin
                repeat (500) @(negedge clk);
                start_cmd = 1'b1;
                div_code  = 4'b0001;
                @(negedge clk) start_cmd = 1'b0;
            end
            measure(1'b1, 3000, td, nd, nc, fc, ne, se);
        join
        check(td == 2048, "R9 R11 second cycle unchanged by start and new code", td, 2048);
        check(nd == 1024, "R6 no lost divided tick across boundary", nd, 1024);
        fork
            begin
                repeat (300) @(negedge clk);
                cont_mode = 1'b0;
            end
            measure(1'b1, 3000, td, nd, nc, fc, ne, se);
        join
        check(td == 1024, "R6 R11 third cycle uses new divide by 1", td, 1024);
        check(nd == 1024, "R1 divide by 1 tick count", nd, 1024);
        check_halt("R5 halt once continuous mode is cleared", 1500);
    endtask

    task automatic t_midrun_change();
        int td, nd, nc, fc, ne, se;
        div_code = 4'b0001; cycle_count = 24'd2; cont_mode = 1'b0;
        pulse_start();
        fork
            begin
                repeat (100) @(negedge clk);
                cycle_count = 24'd1;
                div_code    = 4'b0100;
            end
            measure(1'b0, 5000, td, nd, nc, fc, ne, se);
        join
        check(td == 2048, "R11 mid-cycle setting change held", td, 2048);
        check(nc == 2, "R11 conv ticks with held count", nc, 2);
        check_halt("R5 halt after held-setting cycle", 200);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_single(4'b0001, 1, 1, "R1 div1 N1");
        t_single(4'b0010, 2, 2, "R1 div2 N2");
        t_single(4'b0100, 4, 1, "R1 div4 N1");
        t_single(4'b0011, 1, 1, "R2 code3");
        t_single(4'b0000, 1, 1, "R2 code0");
        t_single(4'b0001, 1, 0, "R4 count0");
        t_single(4'b0001, 1, 10, "R7 R8 count10");
        t_single(4'b0001, 1, 11, "R7 R8 count11");
        t_continuous();
        t_midrun_change();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule